// File: doc/BRIEF.md
# Strided Strip-Mined Vector Address Generator

This block turns one software request (a base byte address, an element stride, a total element count and the hardware vector length) into a stream of element addresses, one per cycle, on a valid/ready request interface. An array longer than the vector register is cut into strips. Every strip except possibly the last holds the full hardware vector length. The last strip holds whatever remains. Before the first request of each strip, the strip's element count is placed on a vector-length output, and it stays there for the whole strip.

Elements are 8 bytes wide. Consecutive elements are `stride` elements apart, so a stride of 1 gives contiguous addresses. Addresses carry on from one strip to the next without going back to the base. A flag marks the last address of each strip, and a second flag marks the last address of the whole transfer. A one-cycle done pulse follows completion. A transfer of zero elements finishes at once and issues no requests.

Top module: `vec_strip_agen`

## Requirements
- R1: After reset, `req_valid`, `busy`, `done`, `strip_last` and `xfer_last` are 0 and `strip_len` is 0.
- R2: Element i of a transfer (counted from 0 across all strips) is requested at byte address `base_addr + i*stride*8`, modulo 2^ADDR_W. A stride of 1 therefore gives addresses 8 bytes apart, and the address never returns to the base when a new strip begins.
- R3: Each strip holds min(remaining elements, hardware vector length) elements. `strip_len` shows that count from before the strip's first request until its last request is accepted.
- R4: A total count that is not a multiple of the vector length ends with a shorter final strip. For example, 1000 elements with a vector length of 16 give 63 strips: 62 of 16 elements and a final strip of 8.
- R5: `strip_last` is 1 exactly while the last request of a strip is presented. `xfer_last` is 1 exactly while the last request of the final strip is presented.
- R6: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr`, `strip_last`, `xfer_last` and `strip_len` hold their values into the next cycle.
- R7: `done` pulses for one cycle on the cycle after the final request is accepted. A start with a total count of 0 pulses `done` on the cycle after start and issues no request.
- R8: A `start` that arrives while `busy` is 1 has no effect on the running transfer.
- R9: A hardware vector length input of 0 is treated as 1.
- R10: `busy` is 1 from the cycle after an accepted nonzero start until the cycle after the final request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| base_addr | input | ADDR_W | Byte address of element 0 |
| stride | input | STRIDE_W | Element stride, in elements |
| total_cnt | input | CNT_W | Total elements to move |
| hw_vl | input | VL_W | Hardware vector length (0 read as 1) |
| busy | output | 1 | Transfer in progress |
| strip_len | output | VL_W | Element count of the current strip |
| req_valid | output | 1 | Request address valid |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | ADDR_W | Element byte address |
| strip_last | output | 1 | Last request of the current strip |
| xfer_last | output | 1 | Last request of the whole transfer |
| done | output | 1 | One-cycle completion pulse |

## Verification
Transfers are run with the ready line held high, toggled every cycle, and driven by a pseudo-random generator. This separates a correct address stepper from one that steps on stalls, and also shows whether outputs stay put under backpressure. The cases cover a count that is an exact multiple of the vector length, a count with a short final strip, a count smaller than one strip, a count of zero, and a vector length input of zero. Between them, these show the difference between a correct minimum and off-by-one strip sizing, and between a missing and a misplaced final-strip flag. A large-stride transfer that starts near the top of the address space checks wraparound, and a long transfer of 1000 elements checks strip continuity and the strip count. Start pulses issued in the middle of a transfer show whether a running transfer is protected from a restart.

// File: rtl/vsa_pkg.sv
// Package for the strided strip-mined address generator.
// Holds the controller state encoding shared by the top module.
package vsa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_ISSUE = 2'd2
    } vsa_state_e;
endpackage

// File: rtl/vsa_strip_ctrl.sv
// Strip sizing: keeps the number of elements not yet assigned to a strip
// and, on each load, takes min(remaining, vector length) as the next strip.
// Assumes CNT_W >= VL_W. A vector length of 0 is latched as 1.
module vsa_strip_ctrl #(
    parameter int CNT_W = 16,
    parameter int VL_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CNT_W-1:0] total_cnt,
    input  logic [VL_W-1:0]  hw_vl,
    input  logic             load,
    input  logic             active,
    output logic [VL_W-1:0]  strip_len,
    output logic             final_strip
);
    logic [CNT_W-1:0] rem_q;
    logic [VL_W-1:0]  vmax_q;
    logic [VL_W-1:0]  len_q;
    logic [VL_W-1:0]  take;

    // Size of the next strip: what remains, capped at the vector length.
    always_comb begin
        if (rem_q < CNT_W'(vmax_q)) take = rem_q[VL_W-1:0];
        else                        take = vmax_q;
    end

    // Latch the transfer size, then carve one strip per load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            vmax_q <= VL_W'(1);
            len_q  <= '0;
        end else if (accept) begin
            rem_q  <= total_cnt;
            vmax_q <= (hw_vl == '0) ? VL_W'(1) : hw_vl;
        end else if (load) begin
            len_q <= take;
            rem_q <= rem_q - CNT_W'(take);
        end
    end

    assign strip_len   = len_q;
    assign final_strip = (rem_q == '0);

    AST_STRIP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (len_q != '0) && (len_q <= vmax_q)) else $error("strip length out of range"); // R3
endmodule

// File: rtl/vsa_elem_ctr.sv
// Position of the current element inside its strip.
// Cleared on every strip load and advanced on each accepted request.
module vsa_elem_ctr #(
    parameter int VL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            active,
    input  logic [VL_W-1:0] strip_len,
    output logic            last_in_strip
);
    logic [VL_W-1:0] idx_q;

    // Count accepted requests within the strip.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= '0;
        else if (load) idx_q <= '0;
        else if (step) idx_q <= idx_q + VL_W'(1);
    end

    assign last_in_strip = (idx_q == strip_len - VL_W'(1));

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx_q < strip_len)) else $error("element index past strip"); // R5
endmodule

// File: rtl/vsa_addr_step.sv
// Strided address accumulator. It loads the base on start and adds
// stride*ELEM_BYTES on every accepted request, with no reset between strips.
// Assumes ELEM_BYTES is a power of two.
module vsa_addr_step #(
    parameter int ADDR_W     = 32,
    parameter int STRIDE_W   = 16,
    parameter int ELEM_BYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] stride,
    input  logic                step,
    output logic [ADDR_W-1:0]   addr
);
    localparam int SHIFT = $clog2(ELEM_BYTES);

    logic [ADDR_W-1:0]   addr_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [ADDR_W-1:0]   inc;

    // Byte increment between consecutive elements.
    assign inc = ADDR_W'(stride_q) << SHIFT;

    // Hold the running address and the latched stride.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
        end else if (accept) begin
            addr_q   <= base_addr;
            stride_q <= stride;
        end else if (step) begin
            addr_q <= addr_q + inc;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/vec_strip_agen.sv
// Top level of the strided strip-mined address generator.
// Sequencing: IDLE -> LOAD (set the strip length) -> ISSUE (one address
// per accepted cycle) -> LOAD for the next strip, or IDLE after the final one.
// Assumes the consumer holds req_ready independently of req_valid.
module vec_strip_agen
    import vsa_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int STRIDE_W   = 16,
    parameter int CNT_W      = 16,
    parameter int VL_W       = 8,
    parameter int ELEM_BYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [CNT_W-1:0]    total_cnt,
    input  logic [VL_W-1:0]     hw_vl,
    output logic                busy,
    output logic [VL_W-1:0]     strip_len,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    output logic                strip_last,
    output logic                xfer_last,
    output logic                done
);
    vsa_state_e state_q;
    logic       done_q;
    logic       accept, load, step, issuing;
    logic       last_in_strip, final_strip;

    assign accept  = start && (state_q == ST_IDLE);
    assign load    = (state_q == ST_LOAD);
    assign issuing = (state_q == ST_ISSUE);
    assign step    = issuing && req_ready;

    // Controller sequencing and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (total_cnt == '0) done_q  <= 1'b1;
                        else                 state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: state_q <= ST_ISSUE;
                ST_ISSUE: begin
                    if (step && last_in_strip) begin
                        if (final_strip) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_LOAD;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    vsa_strip_ctrl #(.CNT_W(CNT_W), .VL_W(VL_W)) u_strip (
        .clk(clk), .rst_n(rst_n), .accept(accept), .total_cnt(total_cnt),
        .hw_vl(hw_vl), .load(load), .active(issuing),
        .strip_len(strip_len), .final_strip(final_strip)
    );

    vsa_elem_ctr #(.VL_W(VL_W)) u_elem (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .active(issuing),
        .strip_len(strip_len), .last_in_strip(last_in_strip)
    );

    vsa_addr_step #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .ELEM_BYTES(ELEM_BYTES)) u_addr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .base_addr(base_addr),
        .stride(stride), .step(step), .addr(req_addr)
    );

    assign busy       = (state_q != ST_IDLE);
    assign req_valid  = issuing;
    assign strip_last = issuing && last_in_strip;
    assign xfer_last  = strip_last && final_strip;
    assign done       = done_q;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(strip_len)
                                       && $stable(strip_last) && $stable(xfer_last))) else $error("stall not held"); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xfer_last) |=> (done && !busy)) else $error("done missing"); // R7
    AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && total_cnt == '0) |=> (done && !busy && !req_valid)) else $error("zero count"); // R7
    AST_XLAST_IN_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_last |-> (strip_last && req_valid)) else $error("xfer_last alone"); // R5
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(req_valid && req_ready && xfer_last)) |=> busy) else $error("busy dropped"); // R10
endmodule

// File: tb/vec_strip_agen_bench.sv
module vec_strip_agen_bench;
    localparam int ADDR_W = 32;
    localparam int STRIDE_W = 16;
    localparam int CNT_W = 16;
    localparam int VL_W = 8;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic              slast;
        logic              xlast;
        logic [VL_W-1:0]   len;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [STRIDE_W-1:0] stride = '0;
    logic [CNT_W-1:0] total_cnt = '0;
    logic [VL_W-1:0] hw_vl = '0;
    logic req_ready = 1'b0;
    logic busy, req_valid, strip_last, xfer_last, done;
    logic [VL_W-1:0] strip_len;
    logic [ADDR_W-1:0] req_addr;

    int checks = 0;
    int failures = 0;
    exp_t q[$];
    bit exp_done = 0;
    int strips_seen = 0;
    int last_len = 0;

    always #2.5 clk = ~clk;

    vec_strip_agen u_vec_strip_agen (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .stride(stride), .total_cnt(total_cnt), .hw_vl(hw_vl), .busy(busy),
        .strip_len(strip_len), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .strip_last(strip_last), .xfer_last(xfer_last),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: the full list of expected requests for a transfer.
    task automatic build(input logic [ADDR_W-1:0] b, input int s, input int n, input int v);
        int vm = (v == 0) ? 1 : v;
        int rem = n;
        int i = 0;
        q.delete();
        while (rem > 0) begin
            int len = (rem < vm) ? rem : vm;
            for (int k = 0; k < len; k++) begin
                exp_t e;
                e.addr  = b + ADDR_W'(longint'(i) * s * 8);
                e.slast = (k == len - 1);
                e.xlast = (k == len - 1) && (rem == len);
                e.len   = VL_W'(len);
                q.push_back(e);
                i++;
            end
            rem -= len;
        end
    endtask

    // Per-cycle comparison at the falling edge, then drive ready.
    task automatic cycle(input int rmode, input int cyc);
        bit r;
        chk(busy == (q.size() > 0), "R10 busy", busy, q.size() > 0);
        chk(done == exp_done, "R7 done", done, exp_done);
        exp_done = 0;
        if (q.size() == 0) begin
            chk(!req_valid, "R7 no request when nothing expected", req_valid, 0);
        end else if (req_valid) begin
            chk(req_addr == q[0].addr, "R2 address", req_addr, q[0].addr);
            chk(strip_len == q[0].len, "R3 strip length", strip_len, q[0].len);
            chk(strip_last == q[0].slast, "R5 strip_last", strip_last, q[0].slast);
            chk(xfer_last == q[0].xlast, "R5 xfer_last", xfer_last, q[0].xlast);
        end
        case (rmode)
            0: r = 1'b1;
            1: r = cyc[0];
            default: r = ($urandom % 4) != 0;
        endcase
        req_ready = r;
        if (req_valid && r && q.size() > 0) begin
            if (q[0].slast) begin
                strips_seen++;
                last_len = q[0].len;
            end
            void'(q.pop_front());
            if (q.size() == 0) exp_done = 1;
        end
    endtask

    task automatic run(input logic [ADDR_W-1:0] b, input int s, input int n, input int v,
                       input int rmode, input bit mid_start);
        int cyc = 0;
        @(negedge clk);
        base_addr = b; stride = STRIDE_W'(s); total_cnt = CNT_W'(n); hw_vl = VL_W'(v);
        start = 1'b1;
        strips_seen = 0;
        last_len = 0;
        @(negedge clk);
        start = 1'b0;
        build(b, s, n, v);
        if (n == 0) exp_done = 1;
        do begin
            if (mid_start && (cyc == 4 || cyc == 9)) begin
                start = 1'b1; base_addr = 32'h5555_0000; total_cnt = 3; stride = 2; // R8
            end else begin
                start = 1'b0;
            end
            cycle(rmode, cyc);
            cyc++;
            @(negedge clk);
        end while (q.size() > 0 || exp_done);
        start = 1'b0;
        cycle(rmode, cyc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!req_valid && !busy && !done && !strip_last && !xfer_last, "R1 reset flags",
            {req_valid, busy, done, strip_last, xfer_last}, 0);
        chk(strip_len == 0, "R1 reset strip_len", strip_len, 0);
        rst_n = 1'b1;
        run(32'h1000, 1, 10, 4, 0, 0);              // R2 contiguous, strips 4,4,2
        chk(strips_seen == 3 && last_len == 2, "R4 short final strip", strips_seen, 3);
        run(32'h8000, 3, 1000, 16, 2, 0);           // R4 1000/16
        chk(strips_seen == 63, "R4 strip count", strips_seen, 63);
        chk(last_len == 8, "R4 final strip length", last_len, 8);
        run(32'h200, 7, 0, 16, 0, 0);               // R7 zero count
        run(32'h4000, 5, 32, 8, 1, 0);              // R6 exact multiple, alternating ready
        chk(strips_seen == 4 && last_len == 8, "R3 exact multiple", strips_seen, 4);
        run(32'h40, 2, 5, 16, 2, 0);                // R3 shorter than one strip
        chk(strips_seen == 1 && last_len == 5, "R3 single short strip", last_len, 5);
        run(32'h100, 1, 3, 0, 0, 0);                // R9 zero vector length
        chk(strips_seen == 3 && last_len == 1, "R9 zero vl as 1", strips_seen, 3);
        run(32'h2000, 4, 20, 8, 1, 1);              // R8 start while busy
        chk(strips_seen == 3 && last_len == 4, "R8 transfer unchanged", strips_seen, 3);
        run(32'hFFFF_FF00, 1000, 12, 5, 2, 0);      // R2 wraparound
        run(32'h0, 9, 300, 255, 2, 0);              // R3 wide vector length
        chk(strips_seen == 2 && last_len == 45, "R4 partial after 255", last_len, 45);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule